// File: doc/BRIEF.md
# Dual-Domain Reset Controller

This block merges every reset request of a two-subsystem chip into one reset output per subsystem: a primary domain and a secondary domain. A request raised on the primary side (the external reset pin, the primary watchdog, a hibernate wake-up or a missing-clock detect) restarts the whole device. The secondary watchdog restarts the secondary domain alone. The power-on request is an asynchronous input that clears all state and holds both domains in reset. Release is always synchronous to `clk`. The watchdog, hibernate and clock-loss requests are digital, `clk`-synchronous levels. The analog detectors behind them sit outside the block.

The external pin is asynchronous. It passes through a two-stage synchronizer and then a filter that accepts a new level only after it has been stable for `FILT_LEN` cycles. Each domain runs a small state machine with three states. `ST_HOLD` is entered from any state while a request is present (the *request* and *re-request* transitions). It moves to `ST_STRETCH` when the requests go quiet (*quiet*). `ST_STRETCH` waits `HOLD_CYC` cycles and then moves to `ST_RUN` (*elapsed*). The secondary domain also counts "primary not running" as a request, so it always leaves reset after the primary.

Each domain has a sticky cause register that software reads and clears through a small port. Only a power-on reset initialises these registers, so they survive the resets they record.

Top module: `rstc_top`

## Requirements
- R1: While `por_req` is high, both reset outputs are low at once, without waiting for a clock edge. Both cause registers then read 0x01, with bit 0 meaning power-on.
- R2: The external pin is active low. A low pulse that reaches the filter for fewer than `FILT_LEN` consecutive cycles has no effect on the outputs or the cause registers. A longer low level resets both domains.
- R3: Any primary-side request resets both domains: the accepted pin level, `wdog_pri`, `hib_wake` or `clk_miss`.
- R4: `wdog_sec` drives `sec_rst_n` low on the next clock edge and never affects `pri_rst_n`.
- R5: A domain's reset output rises exactly `HOLD_CYC`+1 clock edges after the first edge at which that domain sees no request. It never rises while a request is present.
- R6: `sec_rst_n` is low whenever `pri_rst_n` is low. After a primary-side reset, the secondary domain is released `HOLD_CYC`+1 edges after the primary.
- R7: Primary cause register bits are: 0 power-on, 1 external pin, 2 primary watchdog, 3 hibernate, 4 missing clock. Bit 5 always reads 0. A bit is set on the edge after its source is active.
- R8: Secondary cause register bits are: 0 power-on, 2 secondary watchdog, 5 any primary-originated reset. Bits 1, 3 and 4 always read 0.
- R9: A `reg_clr` pulse clears the `reg_wmask` bits of the register picked by `reg_sel`, and only that register. A source still active keeps its bit set, because set wins over clear.
- R10: Cause bits are sticky across all non-power-on resets: recording a new cause leaves earlier bits set.
- R11: `reg_rdata` shows the primary register when `reg_sel` is 0 and the secondary register when it is 1, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_req | input | 1 | Power-on request, async, active high |
| ext_rst_n | input | 1 | External reset pin, async, active low |
| wdog_pri | input | 1 | Primary watchdog reset request |
| wdog_sec | input | 1 | Secondary watchdog reset request |
| hib_wake | input | 1 | Hibernate-exit reset request |
| clk_miss | input | 1 | Missing-clock reset request |
| reg_sel | input | 1 | Register select: 0 primary, 1 secondary |
| reg_clr | input | 1 | Write-1-to-clear strobe |
| reg_wmask | input | 6 | Bits to clear |
| reg_rdata | output | 6 | Selected cause register |
| pri_rst_n | output | 1 | Primary domain reset, active low |
| sec_rst_n | output | 1 | Secondary domain reset, active low |

## Verification
The bound checker watches several rules on every cycle: the secondary domain is in reset whenever the primary is; the primary output falls only after a primary-side request; no release happens until at least `HOLD_CYC` quiet cycles have passed; and each request sets its cause bit on the following edge. Some behaviour only the bench scenarios can show. These are the exact release cycle of each domain, glitch rejection by the pin filter, selective write-1-to-clear while a source is still active, and cause bits persisting across a chain of different resets.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int CAUSE_W = 6;

    // cause bit positions (software decodes these)
    localparam int C_POR   = 0;
    localparam int C_PIN   = 1;
    localparam int C_WDOG  = 2;
    localparam int C_HIB   = 3;
    localparam int C_CLK   = 4;
    localparam int C_UPSTR = 5;

    localparam logic [CAUSE_W-1:0] CAUSE_POR_VAL = CAUSE_W'(1) << C_POR;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } rst_state_e;
endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic por_req,
    input  logic pin_n,
    output logic active
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          act_q;
    logic          raw_act;

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) sync_q <= 2'b11;
        else         sync_q <= {sync_q[0], pin_n};
    end

    assign raw_act = ~sync_q[1];

    // accept a new level only after FILT_LEN stable cycles
    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (raw_act == act_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            act_q <= raw_act;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign active = act_q;
endmodule

// File: rtl/rstc_domain_seq.sv
module rstc_domain_seq
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic por_req,
    input  logic req,
    output logic rst_n
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    rst_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          rst_n_q;

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!req) begin
                    state_d = ST_STRETCH;   // quiet
                    cnt_d   = '0;
                end
            end
            ST_STRETCH: begin
                if (req)                state_d = ST_HOLD;    // re-request
                else if (cnt_q == LAST) state_d = ST_RUN;     // elapsed
                else                    cnt_d   = cnt_q + 1'b1;
            end
            ST_RUN: begin
                if (req) state_d = ST_HOLD;                  // request
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // registered output: glitch-free, released on a clock edge only
    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) rst_n_q <= 1'b0;
        else         rst_n_q <= (state_d == ST_RUN);
    end

    assign rst_n = rst_n_q;
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
    import rstc_pkg::*;
(
    input  logic               clk,
    input  logic               por_req,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic               clr_en,
    input  logic [CAUSE_W-1:0] clr_mask,
    output logic [CAUSE_W-1:0] cause
);
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] kill;

    assign kill = clr_en ? clr_mask : '0;

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) cause_q <= CAUSE_POR_VAL;
        else         cause_q <= (cause_q & ~kill) | set_vec;
    end

    assign cause = cause_q;
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int HOLD_CYC = 4
) (
    input  logic               clk,
    input  logic               por_req,
    input  logic               ext_rst_n,
    input  logic               wdog_pri,
    input  logic               wdog_sec,
    input  logic               hib_wake,
    input  logic               clk_miss,
    input  logic               reg_sel,
    input  logic               reg_clr,
    input  logic [CAUSE_W-1:0] reg_wmask,
    output logic [CAUSE_W-1:0] reg_rdata,
    output logic               pri_rst_n,
    output logic               sec_rst_n
);
    localparam int NDOM = 2;

    logic               ext_act;
    logic               pri_src;
    logic [NDOM-1:0]    dom_req;
    logic [NDOM-1:0]    dom_rst_n;
    logic [CAUSE_W-1:0] set_vec [NDOM];
    logic [CAUSE_W-1:0] cause_q [NDOM];

    rstc_pin_filter #(.FILT_LEN(FILT_LEN)) u_pin (
        .clk     (clk),
        .por_req (por_req),
        .pin_n   (ext_rst_n),
        .active  (ext_act)
    );

    assign pri_src    = ext_act | wdog_pri | hib_wake | clk_miss;
    assign dom_req[0] = pri_src;
    assign dom_req[1] = pri_src | wdog_sec | ~dom_rst_n[0];

    always_comb begin
        set_vec[0]         = '0;
        set_vec[0][C_PIN]  = ext_act;
        set_vec[0][C_WDOG] = wdog_pri;
        set_vec[0][C_HIB]  = hib_wake;
        set_vec[0][C_CLK]  = clk_miss;
        set_vec[1]          = '0;
        set_vec[1][C_WDOG]  = wdog_sec;
        set_vec[1][C_UPSTR] = pri_src;
    end

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        rstc_domain_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
            .clk     (clk),
            .por_req (por_req),
            .req     (dom_req[d]),
            .rst_n   (dom_rst_n[d])
        );
        rstc_cause_reg u_cause (
            .clk      (clk),
            .por_req  (por_req),
            .set_vec  (set_vec[d]),
            .clr_en   (reg_clr && (reg_sel == 1'(d))),
            .clr_mask (reg_wmask),
            .cause    (cause_q[d])
        );
    end

    assign reg_rdata = reg_sel ? cause_q[1] : cause_q[0];
    assign pri_rst_n = dom_rst_n[0];
    assign sec_rst_n = dom_rst_n[1];
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input logic               clk,
    input logic               por_req,
    input logic               pri_src,
    input logic               wdog_pri,
    input logic               wdog_sec,
    input logic               pri_rst_n,
    input logic               sec_rst_n,
    input logic [CAUSE_W-1:0] pri_cause,
    input logic [CAUSE_W-1:0] sec_cause
);
    localparam int CW = $clog2(HOLD_CYC + 2);
    localparam logic [CW-1:0] CMAX = CW'(HOLD_CYC + 1);

    logic [CW-1:0] quiet_cnt;

    // quiet cycles the primary domain has spent in reset
    always_ff @(posedge clk or posedge por_req) begin
        if (por_req)                   quiet_cnt <= '0;
        else if (pri_rst_n || pri_src) quiet_cnt <= '0;
        else if (quiet_cnt != CMAX)    quiet_cnt <= quiet_cnt + 1'b1;
    end

    p_sec_covers_pri_r6: assert property (@(posedge clk) disable iff (por_req)
        !pri_rst_n |-> !sec_rst_n);

    p_pri_only_primary_r4: assert property (@(posedge clk) disable iff (por_req)
        $fell(pri_rst_n) |-> $past(pri_src));

    p_min_stretch_r5: assert property (@(posedge clk) disable iff (por_req)
        $rose(pri_rst_n) |-> (quiet_cnt >= CW'(HOLD_CYC)));

    p_no_release_on_req_r5: assert property (@(posedge clk) disable iff (por_req)
        pri_src |=> !pri_rst_n);

    p_pwdog_logged_r7: assert property (@(posedge clk) disable iff (por_req)
        wdog_pri |=> pri_cause[C_WDOG]);

    p_swdog_logged_r8: assert property (@(posedge clk) disable iff (por_req)
        wdog_sec |=> sec_cause[C_WDOG]);

    p_upstream_logged_r8: assert property (@(posedge clk) disable iff (por_req)
        pri_src |=> sec_cause[C_UPSTR]);
endmodule

bind rstc_top rstc_checker #(.HOLD_CYC(HOLD_CYC)) u_rstc_chk (
    .clk       (clk),
    .por_req   (por_req),
    .pri_src   (pri_src),
    .wdog_pri  (wdog_pri),
    .wdog_sec  (wdog_sec),
    .pri_rst_n (pri_rst_n),
    .sec_rst_n (sec_rst_n),
    .pri_cause (cause_q[0]),
    .sec_cause (cause_q[1])
);

// File: tb/tb_rstc_top.sv
module tb_rstc_top;
    localparam int FL = 4;
    localparam int H  = 4;

    logic       clk = 1'b0;
    logic       por_req, ext_rst_n, wdog_pri, wdog_sec, hib_wake, clk_miss;
    logic       reg_sel, reg_clr;
    logic [5:0] reg_wmask, reg_rdata;
    logic       pri_rst_n, sec_rst_n;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    typedef struct {
        int         kind;   // 0 pri_rst_n, 1 sec_rst_n, 2 reg_rdata
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    rstc_top #(.FILT_LEN(FL), .HOLD_CYC(H)) dut (
        .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n),
        .wdog_pri(wdog_pri), .wdog_sec(wdog_sec), .hib_wake(hib_wake),
        .clk_miss(clk_miss), .reg_sel(reg_sel), .reg_clr(reg_clr),
        .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
        .pri_rst_n(pri_rst_n), .sec_rst_n(sec_rst_n)
    );

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = {7'd0, pri_rst_n};
                1:       act = {7'd0, sec_rst_n};
                default: act = {2'd0, reg_rdata};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic push(int kind, logic [7:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic read_exp(logic sel, logic [7:0] exp, string tag);
        reg_sel = sel;
        push(2, exp, tag);
        tick();
    endtask

    task automatic clear(logic sel, logic [5:0] mask);
        reg_sel = sel; reg_wmask = mask; reg_clr = 1'b1;
        tick();
        reg_clr = 1'b0; reg_wmask = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        por_req = 1'b1; ext_rst_n = 1'b1; wdog_pri = 0; wdog_sec = 0;
        hib_wake = 0; clk_miss = 0; reg_sel = 0; reg_clr = 0; reg_wmask = '0;
        tick(3);
        // R1: power-on state
        push(0, 8'd0, "R1 pri in reset"); push(1, 8'd0, "R1 sec in reset");
        tick();
        read_exp(1'b0, 8'h01, "R1 R11 pri cause after por");
        read_exp(1'b1, 8'h01, "R1 R11 sec cause after por");
        por_req = 1'b0;
        tick(30);
        push(0, 8'd1, "R5 pri released"); push(1, 8'd1, "R6 sec released");
        tick();
        read_exp(1'b0, 8'h01, "R10 pri cause kept");
        clear(1'b0, 6'h3F);
        read_exp(1'b0, 8'h00, "R9 pri cleared");
        read_exp(1'b1, 8'h01, "R9 sec untouched");
        clear(1'b1, 6'h3F);
        read_exp(1'b1, 8'h00, "R9 sec cleared");

        // R3 R5 R6: hibernate reset, exact release edges
        hib_wake = 1'b1;
        tick();
        hib_wake = 1'b0;
        tick(H - 1);
        push(0, 8'd0, "R5 pri still stretching");
        tick();
        push(0, 8'd1, "R5 pri released on time"); push(1, 8'd0, "R6 sec held after pri");
        tick();
        tick(H - 1);
        push(1, 8'd0, "R6 sec still stretching");
        tick();
        push(1, 8'd1, "R6 sec released on time");
        tick();
        read_exp(1'b0, 8'h08, "R7 pri hib bit");
        read_exp(1'b1, 8'h20, "R8 sec upstream bit");

        // R4: secondary watchdog stays local
        wdog_sec = 1'b1;
        push(1, 8'd0, "R4 sec reset"); push(0, 8'd1, "R4 pri unaffected");
        tick();
        wdog_sec = 1'b0;
        for (int i = 0; i < 6; i++) begin
            push(0, 8'd1, "R4 pri stays up");
            tick();
        end
        tick(15);
        push(1, 8'd1, "R4 sec back up");
        tick();
        read_exp(1'b1, 8'h24, "R8 sec wdog bit");
        read_exp(1'b0, 8'h08, "R4 R10 pri cause unchanged");

        // primary watchdog resets both, earlier bits survive
        wdog_pri = 1'b1;
        push(0, 8'd0, "R3 pri wdog reset"); push(1, 8'd0, "R3 sec by pri wdog");
        tick();
        wdog_pri = 1'b0;
        tick(20);
        read_exp(1'b0, 8'h0C, "R10 pri bits accumulate");
        read_exp(1'b1, 8'h24, "R8 sec still set");
        clear(1'b0, 6'h04);
        read_exp(1'b0, 8'h08, "R9 selective clear");
        read_exp(1'b1, 8'h24, "R9 other reg untouched");

        // missing clock held while clearing its bit
        clk_miss = 1'b1;
        tick(2);
        push(0, 8'd0, "R3 clkmiss pri"); push(1, 8'd0, "R3 clkmiss sec");
        tick();
        clear(1'b0, 6'h10);
        read_exp(1'b0, 8'h18, "R9 set wins over clear");
        clk_miss = 1'b0;
        tick(25);
        push(0, 8'd1, "R5 pri up after clkmiss");
        tick();
        clear(1'b1, 6'h3F);

        // R2: short glitch rejected
        ext_rst_n = 1'b0;
        tick(FL - 1);
        ext_rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            push(0, 8'd1, "R2 glitch ignored pri");
            tick();
        end
        push(1, 8'd1, "R2 glitch ignored sec");
        tick();
        read_exp(1'b0, 8'h18, "R2 no pin bit");
        read_exp(1'b1, 8'h00, "R2 no upstream bit");

        // R2 R3: long pin reset
        ext_rst_n = 1'b0;
        tick(FL + 4);
        push(0, 8'd0, "R2 pin accepted pri"); push(1, 8'd0, "R2 pin accepted sec");
        tick();
        ext_rst_n = 1'b1;
        tick(30);
        push(0, 8'd1, "R5 pri up after pin"); push(1, 8'd1, "R6 sec up after pin");
        tick();
        read_exp(1'b0, 8'h1A, "R7 pin bit");
        read_exp(1'b1, 8'h20, "R8 pin is upstream");

        // R1: power-on reinitialises cause registers
        por_req = 1'b1;
        #1;
        push(0, 8'd0, "R1 async pri"); push(1, 8'd0, "R1 async sec");
        tick();
        read_exp(1'b0, 8'h01, "R1 pri cause reinit");
        read_exp(1'b1, 8'h01, "R1 sec cause reinit");
        por_req = 1'b0;
        tick(2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule